// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Unit

This block is the hazard and operand-bypass control for a five-stage in-order pipeline with fetch, decode, execute, memory and writeback stages. It takes register numbers and a few type flags from the instruction in each stage. From these it computes multiplexer selects that route results which have not yet been written back to where they are needed. There are three such destinations: the two execute-stage ALU operands, the decode-stage branch comparator, and the write-data input of data memory.

The same comparisons produce the pipeline control. A hold signal freezes the program counter and the fetch/decode register. A bubble signal turns the decode/execute register into a no-op. A flush signal clears the fetch/decode register when a branch predicted taken turns out not taken. Because store data has its own feedback from the memory/writeback register, a store that directly follows a load of its data register never stalls. The block is purely combinational and holds no state.

Top module: `hazard_fwd_unit`

## Requirements
- R1: When the instruction in EX/MEM writes a nonzero register equal to an execute-stage source, that operand's select is 2'b10.
- R2: When only MEM/WB writes a nonzero register equal to an execute-stage source, the select is 2'b01. When both stages match, 2'b10 wins. With no match the select is 2'b00, meaning the register file.
- R3: Register 0 is never forwarded. A match on register 0 leaves every select at its register-file value and causes no stall.
- R4: A load in ID/EX whose destination (nonzero) equals a decode source that feeds the ALU raises hold and bubble together for that cycle.
- R5: A store in decode whose data register (rs2) is the destination of a load in ID/EX does not stall, provided its base register (rs1) does not match.
- R6: The store-data select (`st_data_sel`) is 1 exactly when the instruction in EX/MEM is a store, MEM/WB holds a load writing a nonzero register, and that register equals the store's data register. Otherwise it is 0.
- R7: A branch in decode stalls (hold and bubble) in three cases: its source matches a register-writing instruction in ID/EX, its source matches a load in EX/MEM, or its source matches either of these together.
- R8: A decode-branch source select (`br_sel_a`/`br_sel_b`) is 1 when EX/MEM holds a non-load that writes that nonzero register. Otherwise it is 0, meaning the register file, which is written before it is read.
- R9: `flush_ifid` is 1 only for a branch in decode that resolves not taken while no hold is raised.
- R10: With no register matches, all selects, hold, bubble and flush are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1 | input | 5 | Decode-stage first source register |
| id_rs2 | input | 5 | Decode-stage second source register (store data) |
| id_store | input | 1 | Decode-stage instruction is a store |
| id_branch | input | 1 | Decode-stage instruction is a branch |
| id_br_taken | input | 1 | Branch outcome resolved in decode (1 = taken) |
| ex_rs1 | input | 5 | Execute-stage first source register |
| ex_rs2 | input | 5 | Execute-stage second source register |
| ex_rd | input | 5 | Execute-stage destination register |
| ex_wr | input | 1 | Execute-stage instruction writes a register |
| ex_load | input | 1 | Execute-stage instruction is a load |
| mem_rs2 | input | 5 | Memory-stage store data register |
| mem_rd | input | 5 | Memory-stage destination register |
| mem_wr | input | 1 | Memory-stage instruction writes a register |
| mem_load | input | 1 | Memory-stage instruction is a load |
| mem_store | input | 1 | Memory-stage instruction is a store |
| wb_rd | input | 5 | Writeback-stage destination register |
| wb_wr | input | 1 | Writeback-stage instruction writes a register |
| wb_load | input | 1 | Writeback-stage instruction is a load |
| alu_sel_a | output | 2 | ALU operand A source: 00 regfile, 01 MEM/WB, 10 EX/MEM |
| alu_sel_b | output | 2 | ALU operand B source, same encoding |
| br_sel_a | output | 1 | Branch comparator A from EX/MEM |
| br_sel_b | output | 1 | Branch comparator B from EX/MEM |
| st_data_sel | output | 1 | Data-memory write data from MEM/WB |
| hold | output | 1 | Freeze PC and IF/ID |
| bubble | output | 1 | Insert no-op into ID/EX |
| flush_ifid | output | 1 | Clear IF/ID after a not-taken branch |

## Verification
Some properties are checked by the assertions whenever an input changes. Register 0 never yields a forwarding select. Hold and bubble always move together. The select code 2'b11 never appears. A double match always resolves to EX/MEM. A flush never coincides with a hold. A store that depends only through its data register on a load directly ahead is never stalled. Other behaviour depends on the full pairing of stage contents and is left to the bench scenarios: the exact stall conditions for branches against ALU results and loads at different distances, the qualification of the store-data path, and the quiet outputs when nothing matches.

// File: rtl/hazard_fwd_unit.sv
module hazard_fwd_unit #(
  parameter int RW = 5
) (
  input  logic [RW-1:0] id_rs1,
  input  logic [RW-1:0] id_rs2,
  input  logic          id_store,
  input  logic          id_branch,
  input  logic          id_br_taken,
  input  logic [RW-1:0] ex_rs1,
  input  logic [RW-1:0] ex_rs2,
  input  logic [RW-1:0] ex_rd,
  input  logic          ex_wr,
  input  logic          ex_load,
  input  logic [RW-1:0] mem_rs2,
  input  logic [RW-1:0] mem_rd,
  input  logic          mem_wr,
  input  logic          mem_load,
  input  logic          mem_store,
  input  logic [RW-1:0] wb_rd,
  input  logic          wb_wr,
  input  logic          wb_load,
  output logic [1:0]    alu_sel_a,
  output logic [1:0]    alu_sel_b,
  output logic          br_sel_a,
  output logic          br_sel_b,
  output logic          st_data_sel,
  output logic          hold,
  output logic          bubble,
  output logic          flush_ifid
);
  localparam logic [RW-1:0] ZERO = '0;

  logic ex_w, mem_w, wb_w;
  assign ex_w  = ex_wr  && (ex_rd  != ZERO);
  assign mem_w = mem_wr && (mem_rd != ZERO);
  assign wb_w  = wb_wr  && (wb_rd  != ZERO);

  function automatic logic [1:0] pick(input logic [RW-1:0] src, input logic mw,
                                      input logic [RW-1:0] mrd, input logic ww,
                                      input logic [RW-1:0] wrd);
    if (mw && mrd == src)      pick = 2'b10;
    else if (ww && wrd == src) pick = 2'b01;
    else                       pick = 2'b00;
  endfunction

  assign alu_sel_a = pick(ex_rs1, mem_w, mem_rd, wb_w, wb_rd);
  assign alu_sel_b = pick(ex_rs2, mem_w, mem_rd, wb_w, wb_rd);

  assign br_sel_a = mem_w && !mem_load && (mem_rd == id_rs1);
  assign br_sel_b = mem_w && !mem_load && (mem_rd == id_rs2);

  assign st_data_sel = mem_store && wb_w && wb_load && (wb_rd == mem_rs2);

  logic ex_hit1, ex_hit2, mem_hit1, mem_hit2, load_use, br_stall;
  assign ex_hit1  = ex_w && (ex_rd == id_rs1);
  assign ex_hit2  = ex_w && (ex_rd == id_rs2);
  assign mem_hit1 = mem_w && mem_load && (mem_rd == id_rs1);
  assign mem_hit2 = mem_w && mem_load && (mem_rd == id_rs2);

  assign load_use = ex_load && (ex_hit1 || (ex_hit2 && !id_store));
  assign br_stall = id_branch && (ex_hit1 || ex_hit2 || mem_hit1 || mem_hit2);

  assign hold       = load_use || br_stall;
  assign bubble     = hold;
  assign flush_ifid = id_branch && !id_br_taken && !hold;

  always_comb begin
    p_zero_not_fwd_r3: assert (!(ex_rs1 == ZERO && alu_sel_a != 2'b00) &&
                               !(ex_rs2 == ZERO && alu_sel_b != 2'b00));
    p_legal_code_r2: assert (alu_sel_a != 2'b11 && alu_sel_b != 2'b11);
    p_newest_wins_r2: assert (!(mem_wr && wb_wr && mem_rd == ex_rs1 && wb_rd == ex_rs1 &&
                                ex_rs1 != ZERO) || alu_sel_a == 2'b10);
    p_hold_bubble_r4: assert (hold == bubble);
    p_store_no_stall_r5: assert (!(id_store && !id_branch && ex_load && ex_rd == id_rs2 &&
                                   ex_rd != id_rs1) || !hold);
    p_flush_excl_r9: assert (!(flush_ifid && hold));
  end
endmodule

// File: tb/tb_hazard_fwd_unit.sv
module tb_hazard_fwd_unit;
  logic clk = 0;
  always #2.5 clk = ~clk;

  logic [4:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rs2, mem_rd, wb_rd;
  logic id_store, id_branch, id_br_taken, ex_wr, ex_load, mem_wr, mem_load, mem_store;
  logic wb_wr, wb_load;
  logic [1:0] alu_sel_a, alu_sel_b;
  logic br_sel_a, br_sel_b, st_data_sel, hold, bubble, flush_ifid;

  int runs = 0, fails = 0;

  hazard_fwd_unit dut (.*);

  task automatic chk(input string req, input int got, input int exp);
    runs++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    {id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rs2, mem_rd, wb_rd} = '0;
    {id_store, id_branch, id_br_taken, ex_wr, ex_load, mem_wr, mem_load, mem_store} = '0;
    {wb_wr, wb_load} = '0;
  endtask

  task automatic settle(); #1; endtask

  task automatic t_quiet();
    idle(); id_rs1 = 3; id_rs2 = 4; ex_rs1 = 5; ex_rs2 = 6; ex_rd = 7; ex_wr = 1;
    mem_rd = 8; mem_wr = 1; wb_rd = 9; wb_wr = 1; settle();
    chk("R10 sel_a", alu_sel_a, 0); chk("R10 sel_b", alu_sel_b, 0);
    chk("R10 hold", hold, 0); chk("R10 bubble", bubble, 0);
    chk("R10 st", st_data_sel, 0); chk("R10 flush", flush_ifid, 0);
  endtask

  task automatic t_fwd();
    idle(); ex_rs1 = 2; ex_rs2 = 3; mem_rd = 2; mem_wr = 1; wb_rd = 3; wb_wr = 1; settle();
    chk("R1 exmem a", alu_sel_a, 2); chk("R2 memwb b", alu_sel_b, 1);
    idle(); ex_rs1 = 6; ex_rs2 = 6; mem_rd = 6; mem_wr = 1; wb_rd = 6; wb_wr = 1; settle();
    chk("R2 both a", alu_sel_a, 2); chk("R2 both b", alu_sel_b, 2);
    idle(); ex_rs1 = 6; mem_rd = 6; mem_wr = 0; wb_rd = 6; wb_wr = 1; settle();
    chk("R2 memwb only", alu_sel_a, 1);
  endtask

  task automatic t_zero();
    idle(); ex_rs1 = 0; ex_rs2 = 0; mem_rd = 0; mem_wr = 1; wb_rd = 0; wb_wr = 1; settle();
    chk("R3 a", alu_sel_a, 0); chk("R3 b", alu_sel_b, 0);
    idle(); id_rs1 = 0; ex_rd = 0; ex_wr = 1; ex_load = 1; settle();
    chk("R3 no stall", hold, 0);
  endtask

  task automatic t_load_use();
    idle(); id_rs1 = 10; ex_rd = 10; ex_wr = 1; ex_load = 1; settle();
    chk("R4 hold rs1", hold, 1); chk("R4 bubble", bubble, 1);
    idle(); id_rs2 = 11; ex_rd = 11; ex_wr = 1; ex_load = 1; settle();
    chk("R4 hold rs2", hold, 1);
    idle(); id_rs1 = 12; ex_rd = 12; ex_wr = 1; settle();
    chk("R4 alu no hold", hold, 0);
  endtask

  task automatic t_store();
    idle(); id_store = 1; id_rs1 = 4; id_rs2 = 7; ex_rd = 7; ex_wr = 1; ex_load = 1; settle();
    chk("R5 no stall", hold, 0);
    idle(); id_store = 1; id_rs1 = 7; id_rs2 = 5; ex_rd = 7; ex_wr = 1; ex_load = 1; settle();
    chk("R5 base stalls", hold, 1);
    idle(); mem_store = 1; mem_rs2 = 7; wb_rd = 7; wb_wr = 1; wb_load = 1; settle();
    chk("R6 sel on", st_data_sel, 1);
    idle(); mem_store = 1; mem_rs2 = 7; wb_rd = 7; wb_wr = 1; wb_load = 0; settle();
    chk("R6 not load", st_data_sel, 0);
    idle(); mem_store = 0; mem_rs2 = 7; wb_rd = 7; wb_wr = 1; wb_load = 1; settle();
    chk("R6 not store", st_data_sel, 0);
    idle(); mem_store = 1; mem_rs2 = 0; wb_rd = 0; wb_wr = 1; wb_load = 1; settle();
    chk("R6 reg0", st_data_sel, 0);
  endtask

  task automatic t_branch();
    idle(); id_branch = 1; id_br_taken = 1; id_rs1 = 9; ex_rd = 9; ex_wr = 1; settle();
    chk("R7 alu ahead", hold, 1); chk("R7 bubble", bubble, 1);
    idle(); id_branch = 1; id_br_taken = 1; id_rs2 = 9; mem_rd = 9; mem_wr = 1; mem_load = 1; settle();
    chk("R7 load two ahead", hold, 1); chk("R8 no load fwd", br_sel_b, 0);
    idle(); id_branch = 1; id_br_taken = 1; id_rs1 = 9; mem_rd = 9; mem_wr = 1; settle();
    chk("R7 no stall", hold, 0); chk("R8 br_sel_a", br_sel_a, 1); chk("R8 br_sel_b", br_sel_b, 0);
    idle(); id_branch = 1; id_br_taken = 0; settle();
    chk("R9 flush", flush_ifid, 1);
    idle(); id_branch = 1; id_br_taken = 0; id_rs1 = 9; ex_rd = 9; ex_wr = 1; settle();
    chk("R9 no flush on hold", flush_ifid, 0);
    idle(); id_branch = 1; id_br_taken = 1; settle();
    chk("R9 taken", flush_ifid, 0);
  endtask

  initial begin
    #50000;
    fails++; runs++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    idle(); settle();
    chk("R10 reset hold", hold, 0); chk("R10 reset sel", alu_sel_a, 0);
    t_quiet(); t_fwd(); t_zero(); t_load_use(); t_store(); t_branch();
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule